// File: doc/BRIEF.md
# Receive Interrupt and Status Controller

This block sits between the top of a receive character FIFO and the processor. Each time a character reaches the FIFO top, it takes that character's status flags (overrun, parity error, end of frame). From them it keeps the readable receive status bits and decides whether to raise a receive interrupt. When it does raise one, it also decides which vector code to present.

Software selects one of three interrupt modes: polling only, interrupt on the first character, or interrupt on every character. A special receive condition is an overrun, an end of frame, or (where enabled) a parity error. It takes priority over a plain character-available interrupt. It changes the vector code only while the status-affects-vector control bit is set.

Overrun and parity errors are sticky. They stay set until an error-reset command, and while set they raise a special condition again at every later character. End of frame is not sticky: it describes only the character now at the FIFO top.

A small state machine tracks first-character mode:

| State | Meaning |
|---|---|
| `ST_IDLE` | First-character mode is not selected. |
| `ST_ARMED` | Waiting for the first character. |
| `ST_SPENT` | The first-character interrupt has been used. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `select` | `ST_IDLE` | `ST_ARMED` | The mode becomes first-character. |
| `consume` | `ST_ARMED` | `ST_SPENT` | A character arrives. |
| `rearm` | `ST_SPENT` | `ST_ARMED` | The re-arm command is issued. |
| `leave` | any state | `ST_IDLE` | The mode is anything else. |

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset, `char_avail`, `irq_req`, `stat_parity`, `stat_overrun` and `stat_eof` are 0, and `vec_code` is 2'b00.
- R2: `char_avail` goes to 1 on the clock edge after a `top_valid` pulse. It goes to 0 on the edge after a `buf_read` strobe. If both come in the same cycle, it stays 1.
- R3: With `irq_mode` at 2'b00 or 2'b11 (polling), no interrupt is raised for any character. The status bits still update.
- R4: With `irq_mode` = 2'b01 (first character), only the first character after the mode is selected raises a character interrupt. Later plain characters raise none.
- R5: In first-character mode, a one-cycle `cmd_rearm` strobe re-arms the mode, so that the next character raises a character interrupt again.
- R6: In first-character mode, a parity error raises no interrupt, but overrun or end of frame raises a special-condition interrupt.
- R7: With `irq_mode` = 2'b10 (every character), every character raises an interrupt.
- R8: In every-character mode, a parity error counts as a special condition only when `parity_special` is 1.
- R9: `stat_overrun` and `stat_parity` stay set once set until `cmd_err_reset`. While either is set, each new character raises a special condition in any mode that allows that flag to interrupt. If an error reset and a new error come in the same cycle, the error stays set.
- R10: `stat_eof` shows the end-of-frame flag of the most recent character only.
- R11: `vec_code` is 2'b00 when no interrupt is pending, 2'b01 for character available, and 2'b10 for a special condition. A special condition wins over character available. With `status_vec_en` = 0, a pending special condition shows as 2'b01.
- R12: `irq_req` is 1 exactly while an interrupt is pending. A `buf_read` with no character arriving in the same cycle clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_valid | input | 1 | One-cycle pulse: a character has reached the FIFO top |
| top_parity | input | 1 | Parity error flag of that character |
| top_overrun | input | 1 | Overrun flag of that character |
| top_eof | input | 1 | End-of-frame flag of that character |
| buf_read | input | 1 | Receive buffer read strobe |
| irq_mode | input | 2 | 00/11 polling, 01 first character, 10 every character |
| parity_special | input | 1 | Parity counts as special condition in every-character mode |
| status_vec_en | input | 1 | Special conditions modify the vector code |
| cmd_rearm | input | 1 | Re-arm first-character mode |
| cmd_err_reset | input | 1 | Clear sticky overrun and parity bits |
| char_avail | output | 1 | Character-available status |
| stat_parity | output | 1 | Sticky parity error status |
| stat_overrun | output | 1 | Sticky overrun status |
| stat_eof | output | 1 | End of frame of the current character |
| irq_req | output | 1 | Receive interrupt request |
| vec_code | output | 2 | Receive vector code |

## Verification
The assertions check three things on every cycle. They check that an arriving character sets the available bit and captures its own end-of-frame flag. They check that the first-character state machine consumes its arm on a character and takes it back on a re-arm. They check that polling mode and a plain buffer read leave no request pending.

Some behaviour depends on a sequence of characters and commands, so only the bench's scenarios can show it. This covers the sticky errors re-raising special conditions across several characters and the parity option differing between modes. It also covers a special condition taking priority over a character interrupt, and the vector mapping with `status_vec_en` cleared.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    localparam int MODE_W = 2;
    localparam int VEC_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_POLL  = 2'b00,
        MODE_FIRST = 2'b01,
        MODE_EVERY = 2'b10,
        MODE_RSVD  = 2'b11
    } irq_mode_t;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE    = 2'b00,
        VEC_CHAR    = 2'b01,
        VEC_SPECIAL = 2'b10
    } vec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_SPENT = 2'b10
    } arm_state_t;

endpackage

// File: rtl/rx_status_latch.sv
module rx_status_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic top_valid,
    input  logic top_parity,
    input  logic top_overrun,
    input  logic top_eof,
    input  logic buf_read,
    input  logic cmd_err_reset,
    output logic par_eff,
    output logic ovr_eff,
    output logic char_avail,
    output logic stat_parity,
    output logic stat_overrun,
    output logic stat_eof
);

    logic par_base;
    logic ovr_base;

    always_comb begin
        par_base = cmd_err_reset ? 1'b0 : stat_parity;
        ovr_base = cmd_err_reset ? 1'b0 : stat_overrun;
        par_eff  = par_base | (top_valid & top_parity);
        ovr_eff  = ovr_base | (top_valid & top_overrun);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_avail   <= 1'b0;
            stat_parity  <= 1'b0;
            stat_overrun <= 1'b0;
            stat_eof     <= 1'b0;
        end else begin
            stat_parity  <= par_eff;
            stat_overrun <= ovr_eff;
            if (top_valid) begin
                char_avail <= 1'b1;
                stat_eof   <= top_eof;
            end else if (buf_read) begin
                char_avail <= 1'b0;
            end
        end
    end

    // R2
    avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |=> char_avail);

    // R10
    eof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |=> (stat_eof == $past(top_eof)));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_overrun && !cmd_err_reset) |=> stat_overrun);

endmodule

// File: rtl/rx_irq_fsm.sv
module rx_irq_fsm
    import rx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] irq_mode,
    input  logic              top_valid,
    input  logic              top_eof,
    input  logic              par_eff,
    input  logic              ovr_eff,
    input  logic              parity_special,
    input  logic              buf_read,
    input  logic              cmd_rearm,
    output vec_t              pending
);

    arm_state_t state_q;
    arm_state_t state_d;
    logic       mode_first;
    logic       mode_every;
    logic       mode_off;
    logic       special_hit;
    logic       char_hit;

    assign mode_first = (irq_mode == MODE_FIRST);
    assign mode_every = (irq_mode == MODE_EVERY);
    assign mode_off   = !(mode_first || mode_every);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (mode_first) state_d = ST_ARMED;
            ST_ARMED: if (!mode_first) state_d = ST_IDLE;
                      else if (top_valid) state_d = ST_SPENT;
            ST_SPENT: if (!mode_first) state_d = ST_IDLE;
                      else if (cmd_rearm) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        special_hit = ovr_eff || top_eof || (par_eff && mode_every && parity_special);
        char_hit    = mode_every || (mode_first && state_q == ST_ARMED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= VEC_NONE;
        end else if (mode_off) begin
            pending <= VEC_NONE;
        end else if (top_valid && special_hit) begin
            pending <= VEC_SPECIAL;
        end else if (top_valid && char_hit) begin
            pending <= VEC_CHAR;
        end else if (buf_read && !top_valid) begin
            pending <= VEC_NONE;
        end
    end

    // R4
    arm_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && mode_first && top_valid) |=> (state_q == ST_SPENT));

    // R5
    arm_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && mode_first && cmd_rearm) |=> (state_q == ST_ARMED));

    // R3
    poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_off |=> (pending == VEC_NONE));

endmodule

// File: rtl/rx_vec_enc.sv
module rx_vec_enc
    import rx_irq_pkg::*;
(
    input  vec_t             pending,
    input  logic             status_vec_en,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec_code
);

    always_comb begin
        irq_req = (pending != VEC_NONE);
        unique case (pending)
            VEC_SPECIAL: vec_code = status_vec_en ? VEC_SPECIAL : VEC_CHAR;
            VEC_CHAR:    vec_code = VEC_CHAR;
            default:     vec_code = VEC_NONE;
        endcase
    end

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              top_valid,
    input  logic              top_parity,
    input  logic              top_overrun,
    input  logic              top_eof,
    input  logic              buf_read,
    input  logic [MODE_W-1:0] irq_mode,
    input  logic              parity_special,
    input  logic              status_vec_en,
    input  logic              cmd_rearm,
    input  logic              cmd_err_reset,
    output logic              char_avail,
    output logic              stat_parity,
    output logic              stat_overrun,
    output logic              stat_eof,
    output logic              irq_req,
    output logic [VEC_W-1:0]  vec_code
);

    logic par_eff;
    logic ovr_eff;
    vec_t pending;

    rx_status_latch u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .top_valid    (top_valid),
        .top_parity   (top_parity),
        .top_overrun  (top_overrun),
        .top_eof      (top_eof),
        .buf_read     (buf_read),
        .cmd_err_reset(cmd_err_reset),
        .par_eff      (par_eff),
        .ovr_eff      (ovr_eff),
        .char_avail   (char_avail),
        .stat_parity  (stat_parity),
        .stat_overrun (stat_overrun),
        .stat_eof     (stat_eof)
    );

    rx_irq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_mode      (irq_mode),
        .top_valid     (top_valid),
        .top_eof       (top_eof),
        .par_eff       (par_eff),
        .ovr_eff       (ovr_eff),
        .parity_special(parity_special),
        .buf_read      (buf_read),
        .cmd_rearm     (cmd_rearm),
        .pending       (pending)
    );

    rx_vec_enc u_enc (
        .pending      (pending),
        .status_vec_en(status_vec_en),
        .irq_req      (irq_req),
        .vec_code     (vec_code)
    );

    // R12
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_read && !top_valid) |=> !irq_req);

endmodule

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       top_valid = 1'b0, top_parity = 1'b0, top_overrun = 1'b0, top_eof = 1'b0;
    logic       buf_read = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic       parity_special = 1'b0, status_vec_en = 1'b1;
    logic       cmd_rearm = 1'b0, cmd_err_reset = 1'b0;
    logic       char_avail, stat_parity, stat_overrun, stat_eof, irq_req;
    logic [1:0] vec_code;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rx_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .top_valid(top_valid), .top_parity(top_parity),
        .top_overrun(top_overrun), .top_eof(top_eof),
        .buf_read(buf_read), .irq_mode(irq_mode),
        .parity_special(parity_special), .status_vec_en(status_vec_en),
        .cmd_rearm(cmd_rearm), .cmd_err_reset(cmd_err_reset),
        .char_avail(char_avail), .stat_parity(stat_parity),
        .stat_overrun(stat_overrun), .stat_eof(stat_eof),
        .irq_req(irq_req), .vec_code(vec_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic p, input logic o, input logic e);
        @(negedge clk);
        top_valid = 1'b1; top_parity = p; top_overrun = o; top_eof = e;
        @(negedge clk);
        top_valid = 1'b0; top_parity = 1'b0; top_overrun = 1'b0; top_eof = 1'b0;
    endtask

    task automatic read_buf();
        @(negedge clk); buf_read = 1'b1;
        @(negedge clk); buf_read = 1'b0;
    endtask

    task automatic err_reset();
        @(negedge clk); cmd_err_reset = 1'b1;
        @(negedge clk); cmd_err_reset = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); irq_mode = m;
        @(negedge clk);
    endtask

    task automatic clean();
        err_reset();
        read_buf();
    endtask

    task automatic t_reset();
        check("R1 char_avail", char_avail, 0);
        check("R1 irq_req", irq_req, 0);
        check("R1 vec_code", vec_code, 0);
        check("R1 status", {stat_parity, stat_overrun, stat_eof}, 0);
    endtask

    task automatic t_avail();
        set_mode(2'b00);
        push(0, 0, 0);
        check("R2 set", char_avail, 1);
        read_buf();
        check("R2 clear", char_avail, 0);
        @(negedge clk);
        top_valid = 1'b1; buf_read = 1'b1;
        @(negedge clk);
        top_valid = 1'b0; buf_read = 1'b0;
        check("R2 simultaneous", char_avail, 1);
        read_buf();
    endtask

    task automatic t_poll();
        set_mode(2'b00);
        push(0, 1, 1);
        check("R3 no irq", irq_req, 0);
        check("R3 status updates", stat_overrun, 1);
        set_mode(2'b11);
        push(1, 0, 0);
        check("R3 rsvd no irq", irq_req, 0);
        clean();
    endtask

    task automatic t_first();
        set_mode(2'b00);
        set_mode(2'b01);
        push(0, 0, 0);
        check("R4 first irq", irq_req, 1);
        check("R4 first vec", vec_code, 1);
        read_buf();
        push(0, 0, 0);
        check("R4 second quiet", irq_req, 0);
        push(1, 0, 0);
        check("R6 parity quiet", irq_req, 0);
        check("R6 parity latched", stat_parity, 1);
        push(0, 0, 1);
        check("R6 eof special", vec_code, 2);
        clean();
        push(0, 1, 0);
        check("R6 overrun special", vec_code, 2);
        clean();
        @(negedge clk); cmd_rearm = 1'b1;
        @(negedge clk); cmd_rearm = 1'b0;
        push(0, 0, 0);
        check("R5 rearm irq", vec_code, 1);
        read_buf();
        push(0, 0, 0);
        check("R5 spent again", irq_req, 0);
        read_buf();
    endtask

    task automatic t_every();
        set_mode(2'b10);
        parity_special = 1'b0;
        for (int i = 0; i < 3; i++) begin
            push(0, 0, 0);
            check("R7 each char", vec_code, 1);
            read_buf();
        end
        push(1, 0, 0);
        check("R8 parity off", vec_code, 1);
        clean();
        parity_special = 1'b1;
        push(1, 0, 0);
        check("R8 parity on", vec_code, 2);
        clean();
        parity_special = 1'b0;
    endtask

    task automatic t_sticky();
        set_mode(2'b10);
        push(0, 1, 0);
        check("R9 ovr special", vec_code, 2);
        read_buf();
        push(0, 0, 0);
        check("R9 sticky respecial", vec_code, 2);
        check("R9 ovr held", stat_overrun, 1);
        err_reset();
        check("R9 cleared", stat_overrun, 0);
        read_buf();
        push(0, 0, 0);
        check("R9 after reset plain", vec_code, 1);
        read_buf();
        @(negedge clk);
        top_valid = 1'b1; top_overrun = 1'b1; cmd_err_reset = 1'b1;
        @(negedge clk);
        top_valid = 1'b0; top_overrun = 1'b0; cmd_err_reset = 1'b0;
        check("R9 set wins", stat_overrun, 1);
        clean();
    endtask

    task automatic t_eof();
        set_mode(2'b10);
        push(0, 0, 1);
        check("R10 eof on", stat_eof, 1);
        read_buf();
        push(0, 0, 0);
        check("R10 eof not latched", stat_eof, 0);
        check("R11 plain after eof", vec_code, 1);
        read_buf();
    endtask

    task automatic t_vec();
        set_mode(2'b10);
        status_vec_en = 1'b0;
        push(0, 0, 1);
        check("R11 sav off irq", irq_req, 1);
        check("R11 sav off vec", vec_code, 1);
        status_vec_en = 1'b1;
        @(negedge clk);
        check("R11 sav on vec", vec_code, 2);
        read_buf();
        check("R12 read clears", irq_req, 0);
        check("R11 none vec", vec_code, 0);
        push(0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        check("R12 held", irq_req, 1);
        read_buf();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_avail();
        t_poll();
        t_first();
        t_every();
        t_sticky();
        t_eof();
        t_vec();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule